// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two dependent entries from a page table in memory. A request carries the virtual address, the kind of access (read, write or execute) and whether the requester runs in kernel or user mode. The block samples the per-process table base frame when it accepts the request.

It first reads the top-level (directory) entry, then the entry in the second-level table that the directory entry points to. Both reads go out over a simple word-read port with a valid/ready request and a response valid. After the walk it gives a one-cycle completion pulse. The pulse comes with either the translated address or a fault code.

The memory port may stall the request or delay the response by any number of cycles. The walk is checked for presence and access rights at both levels. Faults stop the walk as soon as they are detected.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, done_o is 0 and mem_req_valid_o is 0.
- R2: The first read goes to {base_frame, va[31:22], 2'b00} and the second to {directory_entry[31:12], va[21:12], 2'b00}. Every read address is word aligned, and a walk with no fault performs exactly two reads.
- R3: On success, paddr_o is {leaf_entry[31:12], va[11:0]} and fault_o is 0.
- R4: If bit 0 (present) of the directory entry is 0, the walk reports fault code 1 after a single read. Presence is checked before rights at each level.
- R5: If the directory entry is present but bit 0 of the leaf entry is 0, the walk reports fault code 1 after two reads.
- R6: The access code is 0 for read, 1 for write, 2 for execute, and 3 is handled as a read. A write needs bit 1 set in both entries, otherwise fault code 2 is reported. This holds in kernel mode too.
- R7: An execute access needs bit 3 set in both entries, otherwise fault code 2 is reported.
- R8: In user mode (req_kernel_i = 0), bit 2 must be set in both entries, otherwise fault code 2 is reported. In kernel mode, bit 2 has no effect.
- R9: Each accepted request gives exactly one done_o pulse of one cycle. paddr_o and fault_o are valid during that pulse, and fault_o is never 3.
- R10: A request is accepted only while req_ready_o is 1. req_ready_o is 1 only when the block is idle. Requests presented during a walk are ignored.
- R11: While mem_req_valid_o is high and mem_req_ready_i is low, the request and its address stay unchanged. Any stall or response latency gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Idle, request can be taken |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_kernel_i | input | 1 | 1 = kernel mode, 0 = user mode |
| base_frame_i | input | 20 | Directory frame of the current process |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle completion pulse |
| paddr_o | output | 32 | Physical address, valid with done_o when fault_o is 0 |
| fault_o | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
A corrupted walk state shows up at the memory port on the next read. Examples are a stray or missing read, a read address built from the wrong frame or index, or a read count other than one or two. Reads are counted and logged per walk, so this is seen within a single request. A wrong latched access, mode or frame shows as a wrong fault code or physical address in the done cycle of that same request. A stuck state never produces done_o, and the per-request timeout reports it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2, ACC_RSVD = 2'd3} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_ABSENT = 2'd1, FLT_PROT = 2'd2} fault_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_WT_DIR, ST_RD_PTE, ST_WT_PTE, ST_DONE
  } walk_st_e;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_EXEC    = 3;
endpackage

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic [1:0]       acc_i,
  input  logic             kernel_i,
  output logic             present_o,
  output logic             allow_o
);
  logic wr_ok, ex_ok, usr_ok;

  always_comb begin
    present_o = entry_i[BIT_PRESENT];
    wr_ok     = (acc_i != ACC_WRITE) || entry_i[BIT_WRITE];
    ex_ok     = (acc_i != ACC_EXEC)  || entry_i[BIT_EXEC];
    usr_ok    = kernel_i || entry_i[BIT_USER];
    allow_o   = wr_ok && ex_ok && usr_ok;
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int FRAME_W = 20,
  parameter int IDX_W   = 10,
  parameter int ADDR_W  = 32
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int LSB_W = ADDR_W - FRAME_W - IDX_W;

  assign addr_o = {frame_i, idx_i, {LSB_W{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_acc_i,
  input  logic              req_kernel_i,
  input  logic [VA_W-OFF_W-1:0] base_frame_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [VA_W-1:0]   mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [VA_W-1:0]   mem_rsp_data_i,
  output logic              done_o,
  output logic [VA_W-1:0]   paddr_o,
  output logic [1:0]        fault_o
);
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int HI_LSB  = OFF_W + IDX_W;

  walk_st_e          state_q;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q;
  logic              kern_q;
  logic [FRAME_W-1:0] base_q, tbl_q;
  logic [VA_W-1:0]   paddr_q;
  fault_e            fault_q;

  logic              lvl2;
  logic [FRAME_W-1:0] cur_frame;
  logic [IDX_W-1:0]  cur_idx;
  logic              ent_present, ent_allow;

  assign lvl2      = (state_q == ST_RD_PTE) || (state_q == ST_WT_PTE);
  assign cur_frame = lvl2 ? tbl_q : base_q;
  assign cur_idx   = lvl2 ? va_q[OFF_W +: IDX_W] : va_q[HI_LSB +: IDX_W];

  ptw_addr_gen #(.FRAME_W(FRAME_W), .IDX_W(IDX_W), .ADDR_W(VA_W)) u_addr (
    .frame_i (cur_frame),
    .idx_i   (cur_idx),
    .addr_o  (mem_addr_o)
  );

  ptw_perm_chk #(.ENT_W(VA_W)) u_perm (
    .entry_i   (mem_rsp_data_i),
    .acc_i     (acc_q),
    .kernel_i  (kern_q),
    .present_o (ent_present),
    .allow_o   (ent_allow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      kern_q  <= 1'b0;
      base_q  <= '0;
      tbl_q   <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          acc_q   <= req_acc_i;
          kern_q  <= req_kernel_i;
          base_q  <= base_frame_i;
          paddr_q <= '0;
          fault_q <= FLT_NONE;
          state_q <= ST_RD_DIR;
        end
        ST_RD_DIR: if (mem_req_ready_i) state_q <= ST_WT_DIR;
        ST_WT_DIR: if (mem_rsp_valid_i) begin
          if (!ent_present) begin
            fault_q <= FLT_ABSENT;
            state_q <= ST_DONE;
          end else if (!ent_allow) begin
            fault_q <= FLT_PROT;
            state_q <= ST_DONE;
          end else begin
            tbl_q   <= mem_rsp_data_i[VA_W-1 -: FRAME_W];
            state_q <= ST_RD_PTE;
          end
        end
        ST_RD_PTE: if (mem_req_ready_i) state_q <= ST_WT_PTE;
        ST_WT_PTE: if (mem_rsp_valid_i) begin
          if (!ent_present)      fault_q <= FLT_ABSENT;
          else if (!ent_allow)   fault_q <= FLT_PROT;
          else paddr_q <= {mem_rsp_data_i[VA_W-1 -: FRAME_W], va_q[OFF_W-1:0]};
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_RD_DIR) || (state_q == ST_RD_PTE);
  assign done_o          = (state_q == ST_DONE);
  assign paddr_o         = paddr_q;
  assign fault_o         = fault_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  fault_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o != 2'd3));
  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));
  // R2
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_addr_o[1:0] == 2'b00));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_valid_o && !done_o));
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        req_kernel_i = 1'b0;
  logic [19:0] base_frame_i = 20'h10000;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        done_o;
  logic [31:0] paddr_o;
  logic [1:0]  fault_o;

  int n_chk = 0, n_fail = 0, n_reads = 0, lat = 0;
  bit finished = 0;
  logic [31:0] mem [bit [31:0]];
  logic [31:0] addr_log [0:3];

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i, .req_ready_o, .req_vaddr_i, .req_acc_i, .req_kernel_i, .base_frame_i,
    .mem_req_valid_o, .mem_req_ready_i, .mem_addr_o, .mem_rsp_valid_i, .mem_rsp_data_i,
    .done_o, .paddr_o, .fault_o
  );

  localparam logic [3:0] P = 4'h1, W = 4'h2, U = 4'h4, X = 4'h8;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // memory responder
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      mem_req_ready_i = 1'b0;
      if (rst_n && mem_req_valid_o) begin
        repeat (lat) @(negedge clk);
        mem_req_ready_i = 1'b1;
        a = mem_addr_o;
        if (n_reads < 4) addr_log[n_reads] = a;
        n_reads++;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = mem.exists(a) ? mem[a] : 32'h0;
      end
    end
  end

  task automatic map(input logic [31:0] va, input logic [3:0] dflg, input logic [3:0] pflg);
    logic [19:0] tf, pf;
    tf = 20'h20000 + {10'd0, va[31:22]};
    pf = 20'h30000 + {10'd0, va[31:22]};
    mem[{base_frame_i, va[31:22], 2'b00}] = {tf, 8'h00, dflg};
    mem[{tf, va[21:12], 2'b00}] = {pf, 8'h00, pflg};
  endtask

  function automatic logic [31:0] exp_pa(input logic [31:0] va);
    exp_pa = {20'h30000 + {10'd0, va[31:22]}, va[11:0]};
  endfunction

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic k,
                      output logic [31:0] pa, output logic [1:0] f, output int rd);
    int t;
    @(negedge clk);
    n_reads = 0;
    req_valid_i = 1'b1; req_vaddr_i = va; req_acc_i = acc; req_kernel_i = k;
    @(negedge clk);
    req_valid_i = 1'b0;
    t = 0;
    while (!done_o && t < 2000) begin @(negedge clk); t++; end
    chk(done_o, "R9 done", {31'd0, done_o}, 32'd1);
    pa = paddr_o; f = fault_o; rd = n_reads;
    @(negedge clk);
    chk(!done_o, "R9 one-cycle pulse", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk(req_ready_o == 1'b1, "R1 ready", {31'd0, req_ready_o}, 32'd1);
    chk(done_o == 1'b0, "R1 done", {31'd0, done_o}, 32'd0);
    chk(mem_req_valid_o == 1'b0, "R1 mem valid", {31'd0, mem_req_valid_o}, 32'd0);
  endtask

  task automatic t_read_ok();
    logic [31:0] pa; logic [1:0] f; int rd;
    lat = 0;
    walk(32'hdeadbeef, 2'd0, 1'b0, pa, f, rd);
    chk(pa == exp_pa(32'hdeadbeef), "R3 paddr", pa, exp_pa(32'hdeadbeef));
    chk(f == 2'd0, "R3 fault", {30'd0, f}, 32'd0);
    chk(rd == 2, "R2 read count", rd, 32'd2);
    chk(addr_log[0] == {20'h10000, 10'h37a, 2'b00}, "R2 dir addr", addr_log[0], {20'h10000, 10'h37a, 2'b00});
    chk(addr_log[1] == {20'h2037a, 10'h2db, 2'b00}, "R2 pte addr", addr_log[1], {20'h2037a, 10'h2db, 2'b00});
  endtask

  task automatic t_latency();
    logic [31:0] pa; logic [1:0] f; int rd;
    lat = 3;
    walk(32'hdeadbeef, 2'd1, 1'b0, pa, f, rd);
    chk(pa == exp_pa(32'hdeadbeef) && f == 2'd0, "R11 stalled port", pa, exp_pa(32'hdeadbeef));
    lat = 0;
  endtask

  task automatic t_absent();
    logic [31:0] pa; logic [1:0] f; int rd;
    walk(32'h7fc00000, 2'd0, 1'b1, pa, f, rd);
    chk(f == 2'd1, "R4 dir absent fault", {30'd0, f}, 32'd1);
    chk(rd == 1, "R4 single read", rd, 32'd1);
    walk(32'h00401234, 2'd0, 1'b1, pa, f, rd);
    chk(f == 2'd1, "R5 leaf absent fault", {30'd0, f}, 32'd1);
    chk(rd == 2, "R5 two reads", rd, 32'd2);
  endtask

  task automatic t_write();
    logic [31:0] pa; logic [1:0] f; int rd;
    walk(32'h00802345, 2'd1, 1'b1, pa, f, rd);
    chk(f == 2'd2, "R6 leaf not writable (kernel)", {30'd0, f}, 32'd2);
    walk(32'h00802345, 2'd0, 1'b0, pa, f, rd);
    chk(f == 2'd0 && pa == exp_pa(32'h00802345), "R6 read of read-only", pa, exp_pa(32'h00802345));
    walk(32'h00802345, 2'd3, 1'b0, pa, f, rd);
    chk(f == 2'd0, "R6 code 3 as read", {30'd0, f}, 32'd0);
    walk(32'h00c03456, 2'd1, 1'b0, pa, f, rd);
    chk(f == 2'd2, "R6 dir not writable", {30'd0, f}, 32'd2);
    chk(rd == 1, "R6 stops at dir", rd, 32'd1);
  endtask

  task automatic t_exec();
    logic [31:0] pa; logic [1:0] f; int rd;
    walk(32'h00802345, 2'd2, 1'b0, pa, f, rd);
    chk(f == 2'd2, "R7 no exec", {30'd0, f}, 32'd2);
    walk(32'hdeadbeef, 2'd2, 1'b0, pa, f, rd);
    chk(f == 2'd0, "R7 exec allowed", {30'd0, f}, 32'd0);
    walk(32'h00c03456, 2'd2, 1'b0, pa, f, rd);
    chk(f == 2'd2, "R7 dir no exec", {30'd0, f}, 32'd2);
  endtask

  task automatic t_user();
    logic [31:0] pa; logic [1:0] f; int rd;
    walk(32'h01004567, 2'd0, 1'b0, pa, f, rd);
    chk(f == 2'd2, "R8 user on kernel page", {30'd0, f}, 32'd2);
    walk(32'h01004567, 2'd1, 1'b1, pa, f, rd);
    chk(f == 2'd0 && pa == exp_pa(32'h01004567), "R8 kernel ignores user bit", pa, exp_pa(32'h01004567));
    walk(32'h01405678, 2'd0, 1'b0, pa, f, rd);
    chk(f == 2'd2, "R8 dir lacks user bit", {30'd0, f}, 32'd2);
    walk(32'h01405678, 2'd2, 1'b1, pa, f, rd);
    chk(f == 2'd0, "R8 kernel via dir", {30'd0, f}, 32'd0);
  endtask

  task automatic t_busy();
    int t;
    lat = 3;
    @(negedge clk);
    n_reads = 0;
    req_valid_i = 1'b1; req_vaddr_i = 32'hdeadbeef; req_acc_i = 2'd0; req_kernel_i = 1'b0;
    @(negedge clk);
    chk(!req_ready_o, "R10 busy after accept", {31'd0, req_ready_o}, 32'd0);
    req_vaddr_i = 32'h7fc00000;
    repeat (3) @(negedge clk);
    req_valid_i = 1'b0;
    t = 0;
    while (!done_o && t < 2000) begin @(negedge clk); t++; end
    chk(paddr_o == exp_pa(32'hdeadbeef) && fault_o == 2'd0, "R10 later request ignored",
        paddr_o, exp_pa(32'hdeadbeef));
    chk(n_reads == 2, "R10 read count", n_reads, 32'd2);
    @(negedge clk);
    chk(req_ready_o && !mem_req_valid_o, "R10 idle afterwards", {31'd0, req_ready_o}, 32'd1);
    lat = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    map(32'hdeadbeef, P|W|U|X, P|W|U|X);
    map(32'h00401234, P|W|U|X, 4'h0);
    map(32'h00802345, P|W|U|X, P|U);
    map(32'h00c03456, P|U,     P|W|U|X);
    map(32'h01004567, P|W|U|X, P|W|X);
    map(32'h01405678, P|W|X,   P|W|U|X);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_ok();
    t_latency();
    t_absent();
    t_write();
    t_exec();
    t_user();
    t_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule